// File: doc/BRIEF.md
# Posted Write Buffer Bus Front End

This block sits between an internal bus and a slow external memory port. It holds one pending write. When a requester writes to external space, the block stores the write in its single entry and acknowledges it in the same cycle. The requester is then free to continue. The stored write drains to the external port afterwards, and the memory on that port adds wait states by holding its ready input low. While the drain runs, accesses to on-chip peripherals go straight through to a single-cycle peripheral port and are acknowledged at once.

Two requesters share the internal bus: a CPU and a dual-address DMA engine, with the DMA winning ties. Reads are never posted. An external read waits until the pending write has drained, and then it holds the internal bus until the external port returns data. A read from the address that was just written therefore doubles as a confirmation that the write has landed. Cache handling and DMA channel setup are outside this block.

Top module: `pwb_ctrl`

## Requirements
- R1: After synchronous reset, with no requests, ext_req, onchip_sel, cpu_ack and dma_ack are all low.
- R2: An external write (address bit 15 low) with the buffer empty is acknowledged in the cycle it is presented. From the next cycle the external port shows ext_req=1 and ext_we=1 with the same address, data and 2-bit size.
- R3: Once ext_req is high, ext_req, ext_we, ext_addr, ext_wdata and ext_size stay unchanged until a cycle in which ext_rdy is high. The buffer entry is released in the cycle ext_rdy is seen for the write.
- R4: A new external write that arrives while the entry is occupied is stalled. The buffer never takes a second entry. With W wait cycles on the port, a write issued in the cycle after a posted write is acknowledged W+2 cycles after it is first presented.
- R5: An access with address bit 15 high goes to the on-chip port. It is acknowledged in the cycle it is presented, even while an external write is still pending, and a read returns onchip_rdata.
- R6: An external read starts only after the pending write has drained. It is acknowledged in the cycle ext_rdy is seen for it, with rdata equal to ext_rdata. A read issued right behind a posted write therefore takes 2W+3 cycles.
- R7: A read from the address of a just-posted write returns the written data.
- R8: When both requesters present a request in the same cycle, the DMA is served first and the CPU is held. At most one acknowledge is high per cycle.
- R9: A DMA transfer from an on-chip source to an external destination can read its next source word in one cycle while its previous write is still draining. A DMA transfer whose source and destination are both external waits for the previous write before its next read.
- R10: While an external read is in progress, the internal bus stays with the reading requester, and the other requester is not acknowledged until the read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU request, held until acknowledged |
| cpu_we | input | 1 | CPU write enable |
| cpu_size | input | 2 | CPU access size code |
| cpu_addr | input | 16 | CPU address; bit 15 set selects on-chip |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ack | output | 1 | CPU access complete |
| cpu_rdata | output | 32 | CPU read data, valid with cpu_ack |
| dma_req | input | 1 | DMA request, held until acknowledged |
| dma_we | input | 1 | DMA write enable |
| dma_size | input | 2 | DMA access size code |
| dma_addr | input | 16 | DMA address; bit 15 set selects on-chip |
| dma_wdata | input | 32 | DMA write data |
| dma_ack | output | 1 | DMA access complete |
| dma_rdata | output | 32 | DMA read data, valid with dma_ack |
| onchip_sel | output | 1 | Single-cycle on-chip access strobe |
| onchip_we | output | 1 | On-chip write enable |
| onchip_size | output | 2 | On-chip access size |
| onchip_addr | output | 16 | On-chip address |
| onchip_wdata | output | 32 | On-chip write data |
| onchip_rdata | input | 32 | On-chip read data, same cycle |
| ext_req | output | 1 | External cycle request |
| ext_we | output | 1 | External write enable |
| ext_size | output | 2 | External access size |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data, valid with ext_rdy |
| ext_rdy | input | 1 | External cycle completes this cycle |

## Verification
The hardest situation to reach is a read arriving exactly one cycle behind a posted write, while the other requester is also contending. Only then are all three effects visible together: the drain, the read behind it, and the bus being held. Directed sequences issue back-to-back write/read and write/on-chip pairs with fixed wait counts, and they check the exact acknowledge cycle against counts derived from W. Two concurrent random streams then mix both requesters, both targets and a small set of colliding addresses under random wait states. Every read is compared against a reference memory that is updated on each write acknowledge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int SZW = 2;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DMA = 1'b1
    } src_e;

    typedef struct packed {
        logic           we;
        logic [SZW-1:0] size;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
    } xfer_t;

    // Upper address bit selects the on-chip peripheral space.
    function automatic logic is_onchip(input logic [AW-1:0] a);
        return a[AW-1];
    endfunction
endpackage

// File: rtl/pwb_arb.sv
module pwb_arb
    import pwb_pkg::*;
(
    input  logic cpu_req,
    input  logic dma_req,
    input  logic lock,
    input  src_e lock_src,
    output logic sel_valid,
    output src_e sel_src
);
    always_comb begin
        if (lock) begin
            sel_valid = 1'b1;
            sel_src   = lock_src;
        end else begin
            sel_valid = cpu_req | dma_req;
            sel_src   = dma_req ? SRC_DMA : SRC_CPU;
        end
    end
endmodule

// File: rtl/pwb_wbuf.sv
module pwb_wbuf
    import pwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xfer_t load_x,
    input  logic  drain_done,
    output logic  valid,
    output xfer_t entry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            entry <= '0;
        end else if (load) begin
            valid <= 1'b1;
            entry <= load_x;
        end else if (drain_done) begin
            valid <= 1'b0;
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid);

    p_clear_on_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && drain_done) |=> !valid);
endmodule

// File: rtl/pwb_extport.sv
module pwb_extport
    import pwb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           buf_valid,
    input  xfer_t          buf_entry,
    input  logic           rd_start,
    input  logic [AW-1:0]  rd_addr_i,
    input  logic [SZW-1:0] rd_size_i,
    input  src_e           rd_src_i,
    input  logic           ext_rdy,
    output logic           ext_req,
    output logic           ext_we,
    output logic [SZW-1:0] ext_size,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_wdata,
    output logic           rd_active,
    output src_e           rd_owner,
    output logic           rd_done,
    output logic           wr_done
);
    logic [AW-1:0]  rd_addr;
    logic [SZW-1:0] rd_size;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            rd_owner  <= SRC_CPU;
            rd_addr   <= '0;
            rd_size   <= '0;
        end else if (rd_start) begin
            rd_active <= 1'b1;
            rd_owner  <= rd_src_i;
            rd_addr   <= rd_addr_i;
            rd_size   <= rd_size_i;
        end else if (rd_done) begin
            rd_active <= 1'b0;
        end
    end

    // The posted write always owns the port ahead of a read.
    always_comb begin
        ext_req   = buf_valid | rd_active;
        ext_we    = buf_valid & buf_entry.we;
        ext_addr  = buf_valid ? buf_entry.addr : rd_addr;
        ext_size  = buf_valid ? buf_entry.size : rd_size;
        ext_wdata = buf_valid ? buf_entry.data : '0;
        wr_done   = buf_valid & ext_rdy;
        rd_done   = rd_active & ~buf_valid & ext_rdy;
    end

    p_hold_until_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_rdy) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                                   && $stable(ext_wdata) && $stable(ext_size)));

    p_single_read_r10: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> !rd_active);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [SZW-1:0] cpu_size,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic           cpu_ack,
    output logic [DW-1:0]  cpu_rdata,
    input  logic           dma_req,
    input  logic           dma_we,
    input  logic [SZW-1:0] dma_size,
    input  logic [AW-1:0]  dma_addr,
    input  logic [DW-1:0]  dma_wdata,
    output logic           dma_ack,
    output logic [DW-1:0]  dma_rdata,
    output logic           onchip_sel,
    output logic           onchip_we,
    output logic [SZW-1:0] onchip_size,
    output logic [AW-1:0]  onchip_addr,
    output logic [DW-1:0]  onchip_wdata,
    input  logic [DW-1:0]  onchip_rdata,
    output logic           ext_req,
    output logic           ext_we,
    output logic [SZW-1:0] ext_size,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_wdata,
    input  logic [DW-1:0]  ext_rdata,
    input  logic           ext_rdy
);
    xfer_t cpu_x, dma_x, sel_x, buf_entry;
    logic  sel_valid, buf_valid, load, rd_start, rd_active, rd_done, wr_done, ack_any;
    src_e  sel_src, rd_owner;

    assign cpu_x = {cpu_we, cpu_size, cpu_addr, cpu_wdata};
    assign dma_x = {dma_we, dma_size, dma_addr, dma_wdata};
    assign sel_x = (sel_src == SRC_DMA) ? dma_x : cpu_x;

    pwb_arb u_arb (
        .cpu_req  (cpu_req),
        .dma_req  (dma_req),
        .lock     (rd_active),
        .lock_src (rd_owner),
        .sel_valid(sel_valid),
        .sel_src  (sel_src)
    );

    pwb_wbuf u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_x    (sel_x),
        .drain_done(wr_done),
        .valid     (buf_valid),
        .entry     (buf_entry)
    );

    pwb_extport u_ext (
        .clk      (clk),
        .rst      (rst),
        .buf_valid(buf_valid),
        .buf_entry(buf_entry),
        .rd_start (rd_start),
        .rd_addr_i(sel_x.addr),
        .rd_size_i(sel_x.size),
        .rd_src_i (sel_src),
        .ext_rdy  (ext_rdy),
        .ext_req  (ext_req),
        .ext_we   (ext_we),
        .ext_size (ext_size),
        .ext_addr (ext_addr),
        .ext_wdata(ext_wdata),
        .rd_active(rd_active),
        .rd_owner (rd_owner),
        .rd_done  (rd_done),
        .wr_done  (wr_done)
    );

    // Per-target dispatch of the selected request.
    always_comb begin
        ack_any    = 1'b0;
        load       = 1'b0;
        rd_start   = 1'b0;
        onchip_sel = 1'b0;
        if (rd_active) begin
            ack_any = rd_done;
        end else if (sel_valid) begin
            if (is_onchip(sel_x.addr)) begin
                onchip_sel = 1'b1;
                ack_any    = 1'b1;
            end else if (sel_x.we) begin
                load    = ~buf_valid;
                ack_any = ~buf_valid;
            end else begin
                rd_start = ~buf_valid;
            end
        end
    end

    assign onchip_we    = sel_x.we;
    assign onchip_size  = sel_x.size;
    assign onchip_addr  = sel_x.addr;
    assign onchip_wdata = sel_x.data;

    assign cpu_ack   = ack_any & (sel_src == SRC_CPU);
    assign dma_ack   = ack_any & (sel_src == SRC_DMA);
    assign cpu_rdata = rd_active ? ext_rdata : onchip_rdata;
    assign dma_rdata = cpu_rdata;

    p_one_ack_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_ack, dma_ack}));

    p_read_behind_write_r6: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> !buf_valid);

    p_onchip_not_during_read_r10: assert property (@(posedge clk) disable iff (rst)
        onchip_sel |-> !rd_active);
endmodule

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
    logic [1:0]  cpu_size = 0, dma_size = 0;
    logic [15:0] cpu_addr = 0, dma_addr = 0;
    logic [31:0] cpu_wdata = 0, dma_wdata = 0;
    logic        cpu_ack, dma_ack, onchip_sel, onchip_we, ext_req, ext_we;
    logic [31:0] cpu_rdata, dma_rdata, onchip_wdata, ext_wdata, onchip_rdata, ext_rdata;
    logic [1:0]  onchip_size, ext_size;
    logic [15:0] onchip_addr, ext_addr;
    logic        ext_rdy = 1'b0;

    logic [31:0] xmem [64];
    logic [31:0] omem [64];
    logic [31:0] ref_x [64];
    logic [31:0] ref_o [64];

    int n_chk = 0, n_fail = 0;
    int wait_n = 0;
    bit rand_wait = 0;

    always #4 clk = ~clk;

    pwb_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_size(dma_size), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
        .onchip_sel(onchip_sel), .onchip_we(onchip_we), .onchip_size(onchip_size),
        .onchip_addr(onchip_addr), .onchip_wdata(onchip_wdata), .onchip_rdata(onchip_rdata),
        .ext_req(ext_req), .ext_we(ext_we), .ext_size(ext_size), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rdy(ext_rdy)
    );

    assign onchip_rdata = omem[onchip_addr[5:0]];
    assign ext_rdata    = xmem[ext_addr[5:0]];

    always @(posedge clk) begin
        if (ext_req && ext_we && ext_rdy) xmem[ext_addr[5:0]] <= ext_wdata;
        if (onchip_sel && onchip_we) omem[onchip_addr[5:0]] <= onchip_wdata;
    end

    function automatic int exp_stall(input int w);
        return w + 2;
    endfunction

    function automatic int exp_read_behind(input int w);
        return 2 * w + 3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // External memory: W wait cycles, ready when the count reaches zero.
    initial begin
        bit armed = 1;
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!ext_req) begin
                ext_rdy = 1'b0;
                armed = 1;
            end else begin
                if (armed) begin
                    cnt = rand_wait ? int'($urandom % 4) : wait_n;
                    armed = 0;
                end else if (cnt > 0) begin
                    cnt--;
                end
                ext_rdy = (cnt == 0);
            end
        end
    end

    // R3: port fields hold while waiting for ready.
    initial begin
        bit hold = 0;
        logic [15:0] pa;
        logic [31:0] pd;
        logic [1:0]  ps;
        logic        pw;
        forever begin
            @(negedge clk);
            #2;
            if (!rst && hold)
                chk(ext_req && ext_addr == pa && ext_wdata == pd && ext_size == ps && ext_we == pw,
                    "R3 hold", {16'h0, ext_addr}, {16'h0, pa});
            hold = !rst && ext_req && !ext_rdy;
            pa = ext_addr; pd = ext_wdata; ps = ext_size; pw = ext_we;
        end
    end

    task automatic do_acc(input bit is_dma, input bit we, input logic [15:0] a,
                          input logic [31:0] d, input logic [1:0] sz,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        if (is_dma) begin
            dma_req = 1; dma_we = we; dma_addr = a; dma_wdata = d; dma_size = sz;
        end else begin
            cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_size = sz;
        end
        cyc = 0;
        forever begin
            #2;
            cyc++;
            if (is_dma ? dma_ack : cpu_ack) break;
            @(negedge clk);
        end
        rd = is_dma ? dma_rdata : cpu_rdata;
        if (we) begin
            if (a[15]) ref_o[a[5:0]] = d;
            else       ref_x[a[5:0]] = d;
        end
        @(posedge clk);
        #1;
        if (is_dma) dma_req = 0;
        else        cpu_req = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic rand_stream(input bit is_dma, input int n);
        logic [31:0] rd, d;
        logic [15:0] a;
        int cyc;
        for (int i = 0; i < n; i++) begin
            bit we = $urandom % 2;
            bit oc = $urandom % 2;
            a = {oc, 9'h0, 3'b000, 3'($urandom % 8)};
            d = $urandom;
            do_acc(is_dma, we, a, d, 2'($urandom % 4), rd, cyc);
            if (!we)
                chk(rd == (oc ? ref_o[a[5:0]] : ref_x[a[5:0]]),
                    oc ? "R5 random on-chip read" : "R7 random external read",
                    rd, oc ? ref_o[a[5:0]] : ref_x[a[5:0]]);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd, rd2;
        int cyc, cyc2;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            xmem[i] = 0; omem[i] = 0; ref_x[i] = 0; ref_o[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #2;
        chk(!ext_req && !onchip_sel && !cpu_ack && !dma_ack, "R1 reset idle",
            {ext_req, onchip_sel, cpu_ack, dma_ack}, 0);

        // R2: posted write and its appearance on the port
        wait_n = 3;
        do_acc(0, 1, 16'h0010, 32'hA5A5_0001, 2'd2, rd, cyc);
        chk(cyc == 1, "R2 write ack same cycle", cyc, 1);
        @(negedge clk); #2;
        chk(ext_req && ext_we && ext_addr == 16'h0010, "R2 port addr", {16'h0, ext_addr}, 32'h10);
        chk(ext_wdata == 32'hA5A5_0001 && ext_size == 2'd2, "R2 port data/size", ext_wdata, 32'hA5A5_0001);
        settle();

        // R4: second write stalls behind the first
        do_acc(0, 1, 16'h0011, 32'h1111_0000, 2'd2, rd, cyc);
        do_acc(0, 1, 16'h0012, 32'h2222_0000, 2'd1, rd, cyc);
        chk(cyc == exp_stall(3), "R4 stalled write", cyc, exp_stall(3));
        settle();

        // R6 / R7: dummy read of the same address right behind the write
        wait_n = 4;
        do_acc(0, 1, 16'h0020, 32'hC0DE_0020, 2'd2, rd, cyc);
        do_acc(0, 0, 16'h0020, 0, 2'd2, rd, cyc);
        chk(cyc == exp_read_behind(4), "R6 read waits for drain", cyc, exp_read_behind(4));
        chk(rd == 32'hC0DE_0020, "R7 dummy read data", rd, 32'hC0DE_0020);
        settle();
        wait_n = 2;
        do_acc(0, 1, 16'h0030, 32'hD0D0_0030, 2'd2, rd, cyc);
        do_acc(0, 0, 16'h0011, 0, 2'd2, rd, cyc);
        chk(cyc == exp_read_behind(2), "R6 other-address read waits", cyc, exp_read_behind(2));
        chk(rd == 32'h1111_0000, "R6 read data", rd, 32'h1111_0000);
        settle();

        // R5: on-chip bypasses a pending external write
        wait_n = 5;
        do_acc(0, 1, 16'h0008, 32'hEEEE_0008, 2'd2, rd, cyc);
        do_acc(0, 1, 16'h8004, 32'hF00D_0004, 2'd0, rd, cyc);
        chk(cyc == 1, "R5 on-chip write bypass", cyc, 1);
        do_acc(0, 0, 16'h8004, 0, 2'd0, rd, cyc);
        chk(cyc == 1 && rd == 32'hF00D_0004, "R5 on-chip read bypass", rd, 32'hF00D_0004);
        @(negedge clk); #2;
        chk(ext_req && ext_we && ext_addr == 16'h0008, "R5 write still pending", {31'h0, ext_req}, 1);
        settle();

        // R8: simultaneous requests, DMA first
        fork
            do_acc(0, 1, 16'h8010, 32'h0C0C_0010, 2'd2, rd, cyc);
            do_acc(1, 1, 16'h8011, 32'h0D0D_0011, 2'd2, rd2, cyc2);
        join
        chk(cyc2 == 1, "R8 DMA served first", cyc2, 1);
        chk(cyc == 2, "R8 CPU held one cycle", cyc, 2);

        // R9: DMA dual transfers
        wait_n = 3;
        do_acc(1, 1, 16'h0012, 32'h5151_0012, 2'd2, rd, cyc);
        do_acc(1, 0, 16'h8011, 0, 2'd2, rd, cyc);
        chk(cyc == 1 && rd == 32'h0D0D_0011, "R9 on-chip source read overlaps", cyc, 1);
        settle();
        do_acc(1, 1, 16'h0013, 32'h6161_0013, 2'd2, rd, cyc);
        do_acc(1, 0, 16'h0012, 0, 2'd2, rd, cyc);
        chk(cyc == exp_read_behind(3), "R9 ext-to-ext read waits", cyc, exp_read_behind(3));
        chk(rd == 32'h5151_0012, "R9 ext source data", rd, 32'h5151_0012);
        settle();

        // R10: bus held by an external read
        wait_n = 4;
        fork
            do_acc(0, 0, 16'h0013, 0, 2'd2, rd, cyc);
            begin
                @(negedge clk);
                do_acc(1, 1, 16'h8020, 32'h7777_0020, 2'd2, rd2, cyc2);
            end
        join
        chk(cyc == exp_stall(4) && rd == 32'h6161_0013, "R10 read completes", cyc, exp_stall(4));
        chk(cyc2 == exp_stall(4), "R10 other requester held", cyc2, exp_stall(4));
        settle();

        // Random mixed traffic from both requesters
        rand_wait = 1;
        fork
            rand_stream(0, 250);
            rand_stream(1, 250);
        join
        settle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule